// File: doc/BRIEF.md
# Loadable up/down counter with direction-aware terminal count

This block is a parameterised binary counter for datapath use. Each clock cycle it does one of four things: it clears, it takes a parallel value, it steps by one, or it keeps its value. A direction input picks the step. Counting up takes the next value from a chain of half adders. Counting down takes it from a chain of full adders that adds the all-ones pattern, which equals subtracting one. Both directions wrap modulo 2^WIDTH.

A terminal-count flag marks the last value before a wrap in the direction now selected. When counting up, that value is all ones. When counting down, it is all zeros. The flag is decoded combinationally from the register and the direction input. A change of direction therefore changes the flag in the same cycle, without waiting for a clock edge. A controller can use the flag to stop counting or to reload at the end of a range.

Top module: `updn_counter`

## Requirements
- R1: When rst_n is low at a rising clock edge, count becomes zero, whatever load, cnt_en and dir_up are.
- R2: When load is 1 at a rising edge (rst_n high), count takes the value of din at that edge.
- R3: Load wins over cnt_en when both are 1 in the same cycle: count takes din, not a stepped value.
- R4: With load 0, cnt_en 1 and dir_up 1 (up), count becomes its previous value plus one.
- R5: With load 0, cnt_en 1 and dir_up 0 (down), count becomes its previous value minus one.
- R6: With load 0 and cnt_en 0, count keeps its value, whatever dir_up is.
- R7: Counting up from all ones gives zero (for WIDTH 4, 4'hF goes to 4'h0).
- R8: Counting down from zero gives all ones (for WIDTH 4, 4'h0 goes to 4'hF).
- R9: While dir_up is 1, term is 1 exactly when every bit of count is 1.
- R10: While dir_up is 0, term is 1 exactly when every bit of count is 0.
- R11: term follows a change of dir_up in the same cycle, and count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, clears the count |
| load | input | 1 | Parallel load strobe, takes priority over counting |
| din | input | WIDTH | Value to load |
| cnt_en | input | 1 | Count enable, one step per cycle while high |
| dir_up | input | 1 | Direction select: 1 counts up, 0 counts down |
| count | output | WIDTH | Current counter value |
| term | output | 1 | Terminal count for the current direction |

## Verification
The bench builds the counter with the default WIDTH of 4. At that width there are only 16 states, so both wrap points can be reached from a load in one or two steps. A full climb through every value also fits in a few cycles, and it shows the terminal flag rises only at the top. The vector table sets load and count enable high together to test their priority. It also flips the direction while the count is held at zero and at all ones, to show the flag changes in the same cycle while the count stays put.

// File: rtl/updn_pkg.sv
// Package updn_pkg
// Holds what the counter modules share: the encoding of the direction
// input and the default width. Assumes nothing beyond IEEE 1800-2017.
package updn_pkg;

    // Level on dir_up that selects counting up; the other level counts down.
    localparam logic DIR_UP   = 1'b1;
    localparam logic DIR_DOWN = 1'b0;

    // Default counter width.
    localparam int unsigned DEF_WIDTH = 4;

    // Which source feeds the count register in a cycle.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'b00,
        SRC_STEP  = 2'b01,
        SRC_LOAD  = 2'b10,
        SRC_CLEAR = 2'b11
    } next_src_e;

endpackage

// File: rtl/updn_incr.sv
// Module updn_incr
// Adds one to the input with a ripple chain of half adders. The constant
// one enters as the carry into bit 0. The carry out of the top bit is
// dropped, so all ones wraps to zero. Purely combinational. Assumes WIDTH >= 1.
module updn_incr #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] val_in,
    output logic [WIDTH-1:0] val_out
);

    // carry[i] is the carry entering bit i; carry[WIDTH] is discarded.
    logic [WIDTH:0] carry;

    assign carry[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_half_add
            // One half adder per bit: sum is XOR, carry is AND.
            assign val_out[gi]   = val_in[gi] ^ carry[gi];
            assign carry[gi+1]   = val_in[gi] & carry[gi];
        end
    endgenerate

    // Wrap on overflow: the carry out of the top bit has no sink.
    logic unused_carry;
    assign unused_carry = carry[WIDTH];

endmodule

// File: rtl/updn_decr.sv
// Module updn_decr
// Subtracts one from the input by adding the all-ones pattern (the two's
// complement of one) in a ripple chain of full adders with no carry in.
// The final carry is dropped, so zero wraps to all ones. Purely
// combinational. Assumes WIDTH >= 1.
module updn_decr #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] val_in,
    output logic [WIDTH-1:0] val_out
);

    localparam logic [WIDTH-1:0] ADDEND = {WIDTH{1'b1}};

    // carry[i] is the carry entering bit i.
    logic [WIDTH:0] carry;

    assign carry[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_full_add
            // One full adder per bit with the second operand fixed to one.
            logic half_sum;
            assign half_sum      = val_in[gi] ^ ADDEND[gi];
            assign val_out[gi]   = half_sum ^ carry[gi];
            assign carry[gi+1]   = (val_in[gi] & ADDEND[gi]) | (half_sum & carry[gi]);
        end
    endgenerate

    // The carry out of the top bit is dropped on purpose (modulo arithmetic).
    logic unused_carry;
    assign unused_carry = carry[WIDTH];

endmodule

// File: rtl/updn_tc_detect.sv
// Module updn_tc_detect
// Flags the end of the range for the selected direction: an AND of all bits
// when counting up, a NOR of all bits when counting down. Purely
// combinational, so the flag follows both the value and the direction at once.
module updn_tc_detect
    import updn_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] val_in,
    input  logic             dir_up,
    output logic             tc
);

    logic all_ones;
    logic all_zeros;

    // Reduction detectors, one per direction.
    assign all_ones  = &val_in;
    assign all_zeros = ~(|val_in);

    // Direction picks which detector drives the flag.
    always_comb begin
        if (dir_up == DIR_UP) begin
            tc = all_ones;
        end else begin
            tc = all_zeros;
        end
    end

endmodule

// File: rtl/updn_counter.sv
// Module updn_counter
// Top of the loadable up/down counter. Priority in each cycle is: synchronous
// reset (rst_n low), then parallel load, then one step in the selected
// direction while cnt_en is high, otherwise hold. The terminal flag is
// combinational from the register and dir_up. Assumes WIDTH >= 1 and that
// all inputs are synchronous to clk.
module updn_counter
    import updn_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en,
    input  logic             dir_up,
    output logic [WIDTH-1:0] count,
    output logic             term
);

    localparam logic [WIDTH-1:0] ZERO = {WIDTH{1'b0}};
    localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] plus_one;
    logic [WIDTH-1:0] minus_one;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] cnt_d;
    next_src_e        src;

    // Incrementer path for counting up.
    updn_incr #(.WIDTH(WIDTH)) u_incr (
        .val_in  (cnt_q),
        .val_out (plus_one)
    );

    // Decrementer path for counting down.
    updn_decr #(.WIDTH(WIDTH)) u_decr (
        .val_in  (cnt_q),
        .val_out (minus_one)
    );

    // Terminal count for the direction now selected.
    updn_tc_detect #(.WIDTH(WIDTH)) u_tc (
        .val_in  (cnt_q),
        .dir_up  (dir_up),
        .tc      (term)
    );

    // Direction mux between the two arithmetic paths.
    assign stepped = (dir_up == DIR_UP) ? plus_one : minus_one;

    // Priority decode of the register source.
    always_comb begin
        if (!rst_n) begin
            src = SRC_CLEAR;
        end else if (load) begin
            src = SRC_LOAD;
        end else if (cnt_en) begin
            src = SRC_STEP;
        end else begin
            src = SRC_HOLD;
        end
    end

    // Next-value mux driven by the decoded source.
    always_comb begin
        unique case (src)
            SRC_CLEAR: cnt_d = ZERO;
            SRC_LOAD:  cnt_d = din;
            SRC_STEP:  cnt_d = stepped;
            default:   cnt_d = cnt_q;
        endcase
    end

    // Count register.
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // ---------------- assertions guarding the logic above ----------------

    // R1: a low reset at an edge clears the count.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (count == ZERO));

    // R2 and R3: a load takes din, even with cnt_en high.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(din)));

    // R4 and R7: one step up, wrapping at all ones.
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_en && dir_up) |=> (count == WIDTH'($past(count) + 1'b1)));

    // R5 and R8: one step down, wrapping at zero.
    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_en && !dir_up) |=> (count == WIDTH'($past(count) - 1'b1)));

    // R6: no load and no enable leaves the count alone.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cnt_en) |=> $stable(count));

    // R9: while counting up, the flag is raised only at all ones.
    assert_term_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_up && term) |-> (count == ONES));

    // R10: while counting down, the flag is raised only at zero.
    assert_term_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_up && term) |-> (count == ZERO));

endmodule

// File: tb/updn_counter_tb.sv
`timescale 1ns/1ps
// Bench for updn_counter at WIDTH 4: a vector table walked by one loop,
// then directed tests for reset and the full upward sweep.
module updn_counter_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         load;
    logic [W-1:0] din;
    logic         cnt_en;
    logic         dir_up;
    logic [W-1:0] count;
    logic         term;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    updn_counter #(.WIDTH(W)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .din    (din),
        .cnt_en (cnt_en),
        .dir_up (dir_up),
        .count  (count),
        .term   (term)
    );

    // One row: inputs for one cycle, then count and term expected after the edge.
    typedef struct packed {
        logic [3:0] req;
        logic       ld;
        logic [3:0] d;
        logic       en;
        logic       up;
        logic [3:0] q;
        logic       tc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{req:4'd2,  ld:1'b1, d:4'hE, en:1'b0, up:1'b1, q:4'hE, tc:1'b0}, // R2 load
        '{req:4'd9,  ld:1'b0, d:4'h0, en:1'b1, up:1'b1, q:4'hF, tc:1'b1}, // R4, R9 top
        '{req:4'd7,  ld:1'b0, d:4'h0, en:1'b1, up:1'b1, q:4'h0, tc:1'b0}, // R7 wrap up
        '{req:4'd8,  ld:1'b0, d:4'h0, en:1'b1, up:1'b0, q:4'hF, tc:1'b0}, // R8 wrap down
        '{req:4'd6,  ld:1'b0, d:4'h3, en:1'b0, up:1'b0, q:4'hF, tc:1'b0}, // R6 hold
        '{req:4'd3,  ld:1'b1, d:4'h1, en:1'b1, up:1'b0, q:4'h1, tc:1'b0}, // R3 priority
        '{req:4'd10, ld:1'b0, d:4'h0, en:1'b1, up:1'b0, q:4'h0, tc:1'b1}, // R5, R10 bottom
        '{req:4'd11, ld:1'b0, d:4'h0, en:1'b0, up:1'b1, q:4'h0, tc:1'b0}, // R11 dir flip
        '{req:4'd2,  ld:1'b1, d:4'h5, en:1'b0, up:1'b1, q:4'h5, tc:1'b0}, // R2 load
        '{req:4'd5,  ld:1'b0, d:4'h0, en:1'b1, up:1'b0, q:4'h4, tc:1'b0}, // R5 down
        '{req:4'd4,  ld:1'b0, d:4'h0, en:1'b1, up:1'b1, q:4'h5, tc:1'b0}, // R4 up
        '{req:4'd9,  ld:1'b1, d:4'hF, en:1'b0, up:1'b1, q:4'hF, tc:1'b1}, // R9 at top
        '{req:4'd11, ld:1'b0, d:4'h0, en:1'b0, up:1'b0, q:4'hF, tc:1'b0}  // R11 dir flip
    };

    // Compare one sample with its expectation.
    task automatic check(input string req, input logic [W-1:0] q_exp, input logic tc_exp);
        checks++;
        if (count !== q_exp || term !== tc_exp) begin
            failures++;
            $display("FAIL %s: count=%h term=%b expected count=%h term=%b",
                     req, count, term, q_exp, tc_exp);
        end
    endtask

    // Drive one cycle of inputs, let the edge pass, sample 1 ns after it.
    task automatic cycle(input logic ld, input logic [W-1:0] d, input logic en, input logic up);
        load = ld; din = d; cnt_en = en; dir_up = up;
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load = 1'b0; din = '0; cnt_en = 1'b0; dir_up = 1'b1;
        #1;
        // R1: reset with load and enable active still clears.
        cycle(1'b1, 4'h9, 1'b1, 1'b1);
        cycle(1'b1, 4'h9, 1'b1, 1'b1);
        check("R1 reset state", 4'h0, 1'b0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            cycle(VECS[i].ld, VECS[i].d, VECS[i].en, VECS[i].up);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].q, VECS[i].tc);
        end

        // R1: reset in the middle of counting.
        cycle(1'b1, 4'h9, 1'b0, 1'b1);
        rst_n = 1'b0;
        cycle(1'b1, 4'h7, 1'b1, 1'b0);
        check("R1 mid-run reset (down dir, term on zero)", 4'h0, 1'b1);
        rst_n = 1'b1;

        // R4/R9: full upward sweep, flag only at 4'hF.
        for (int k = 1; k <= 16; k++) begin
            cycle(1'b0, 4'h0, 1'b1, 1'b1);
            check($sformatf("R9 sweep step %0d", k), W'(k), (k == 15));
        end

        // R6: hold with dir down for several cycles, term on zero.
        for (int k = 0; k < 3; k++) begin
            cycle(1'b0, 4'hA, 1'b0, 1'b0);
            check("R6 hold down", 4'h0, 1'b1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule